// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block gathers interrupt requests that are sorted into priority levels and decides when a processor should take an interrupt. Every level holds a vector of pending sources. A per-level summary bit is high whenever any source at that level is pending. Three commands change this state: one posts a single source, one clears a single source, and one wipes every level at once. A processor-side interrupt-pending output is raised while any summary bit is set, but only when the two low bits of the current instruction address are zero.

A second request source, the processor's software-request register, arrives as an input vector. When an evaluate strobe is given, the block scans the software levels and then the external levels to work out a priority and a summary mask. It compares that priority with the processor's current threshold. If the interrupt is taken, the priority and the mask are latched and marked valid. A later acknowledge copies them into a visible summary register and an interrupt ID register.

Both kinds of malformed traffic are reported through sticky error flags and change no state. Malformed traffic means a command that names a level or source out of range, or an acknowledge with nothing latched.

Top module: `irq_level_ctrl`

## Requirements
- R1: A post with level below 32 and index below 64 sets that source's pending bit, and in the next cycle `lvl_summary` bit [level] reads 1.
- R2: A clear removes one source's pending bit. `lvl_summary` bit [level] drops to 0 only once no source at that level remains pending.
- R3: Clear-all empties every level, and `lvl_summary` reads 0 in the next cycle. It takes precedence over any post or clear issued in the same cycle.
- R4: `irq_pending` is 1 exactly when `lvl_summary` is non-zero and `pc_low` equals 2'b00.
- R5: Each set bit i of `sw_req`, for i in 1..15, is a software level with priority i-1+1 (= i). The highest such level wins, and bit i is set in the mask.
- R6: The external levels 16..31 are scanned after the software levels, using `lvl_summary`. An active level i gives priority i and overrides any software priority. Its bit i is ORed into the mask.
- R7: On a cycle with `eval` high, the interrupt is taken only if the priority is non-zero and strictly greater than `threshold`. When it is taken, `fire` pulses in the next cycle, `info_valid` becomes 1, and the priority and mask are latched. When it is not taken, `fire` stays 0 and `info_valid` keeps its value.
- R8: An `ack` while `info_valid` is 1 loads the latched mask into `isr_out` and the latched priority into `intid_out` in the next cycle, and clears `info_valid`. If `eval` takes a new interrupt in the same cycle, `info_valid` stays 1.
- R9: A post or clear whose level is 32 or more, or whose index is 64 or more, changes no pending state and sets the sticky `cmd_err`.
- R10: An `ack` while `info_valid` is 0 leaves `isr_out` and `intid_out` unchanged and sets the sticky `ack_err`.
- R11: When a post and a clear name the same level and index in the same cycle, the post wins and the bit ends up set.
- R12: After reset, all pending state, `lvl_summary`, `fire`, `info_valid`, `isr_out`, `intid_out`, `cmd_err` and `ack_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_en | input | 1 | Post command strobe |
| post_lvl | input | 6 | Level of the post command |
| post_idx | input | 7 | Source index of the post command |
| clr_en | input | 1 | Clear command strobe |
| clr_lvl | input | 6 | Level of the clear command |
| clr_idx | input | 7 | Source index of the clear command |
| clr_all | input | 1 | Empty every level |
| sw_req | input | 32 | Software request vector, one bit per level |
| pc_low | input | 2 | Two low bits of the current instruction address |
| threshold | input | 5 | Processor's current priority threshold |
| eval | input | 1 | Evaluate strobe |
| ack | input | 1 | Commit the latched priority and mask |
| irq_pending | output | 1 | Interrupt pending towards the processor |
| lvl_summary | output | 32 | Per-level summary status |
| fire | output | 1 | One-cycle pulse after an evaluation that took an interrupt |
| info_valid | output | 1 | Latched priority and mask wait for an acknowledge |
| isr_out | output | 32 | Committed summary mask |
| intid_out | output | 5 | Committed interrupt priority |
| cmd_err | output | 1 | Sticky flag for an out-of-range command |
| ack_err | output | 1 | Sticky flag for an acknowledge with nothing latched |

## Verification
Assertions check the following on every cycle:
- the effect of a valid post on its summary bit;
- the emptying done by clear-all;
- the stillness of the summary after a rejected command;
- the latch, commit and stray-acknowledge rules of the commit stage;
- the address-alignment gate on `irq_pending`.

Three behaviours depend on sequences and can only be shown by the bench's scenarios:
- how the software and external priority mappings interact, and that an external level overrides a software one;
- that a level's summary bit survives a clear while other sources at that level remain;
- post-over-clear precedence on the same bit.

These scenarios are compared against a behavioural model on every clock.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  // Default geometry shared by the controller and its sub-blocks
  localparam int DEF_LEVELS  = 32;
  localparam int DEF_SOURCES = 64;
  localparam int DEF_SW_LO   = 1;
  localparam int DEF_SW_HI   = 16;  // exclusive
  localparam int DEF_EX_LO   = 16;
  localparam int DEF_EX_HI   = 32;  // exclusive

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_OK   = 2'd1,
    CMD_BAD  = 2'd2
  } cmd_class_e;
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store
  import irq_lvl_pkg::*;
#(
  parameter int NL  = DEF_LEVELS,
  parameter int NS  = DEF_SOURCES,
  parameter int LIW = $clog2(NL) + 1,
  parameter int SIW = $clog2(NS) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           post_en,
  input  logic [LIW-1:0] post_lvl,
  input  logic [SIW-1:0] post_idx,
  input  logic           clr_en,
  input  logic [LIW-1:0] clr_lvl,
  input  logic [SIW-1:0] clr_idx,
  input  logic           clr_all,
  output logic [NL-1:0]  summary_q,
  output logic           cmd_err_q
);
  localparam int LW = $clog2(NL);
  localparam int SW = $clog2(NS);

  cmd_class_e post_cls, clr_cls;

  always_comb begin
    post_cls = CMD_NONE;
    if (post_en)
      post_cls = (int'(post_lvl) < NL && int'(post_idx) < NS) ? CMD_OK : CMD_BAD;
    clr_cls = CMD_NONE;
    if (clr_en)
      clr_cls = (int'(clr_lvl) < NL && int'(clr_idx) < NS) ? CMD_OK : CMD_BAD;
  end

  logic post_ok, clr_ok, any_bad;
  assign post_ok = (post_cls == CMD_OK);
  assign clr_ok  = (clr_cls == CMD_OK);
  assign any_bad = (post_cls == CMD_BAD) || (clr_cls == CMD_BAD);

  logic [NS-1:0] post_bit, clr_bit;
  assign post_bit = NS'(1) << post_idx[SW-1:0];
  assign clr_bit  = NS'(1) << clr_idx[SW-1:0];

  for (genvar l = 0; l < NL; l++) begin : g_row
    logic [NS-1:0] row_q, row_n, set_m, kill_m;
    assign set_m  = (post_ok && post_lvl[LW-1:0] == LW'(l)) ? post_bit : '0;
    assign kill_m = (clr_ok  && clr_lvl[LW-1:0]  == LW'(l)) ? clr_bit  : '0;
    // post applied after clear so a same-bit collision leaves it set
    assign row_n  = clr_all ? '0 : ((row_q & ~kill_m) | set_m);
    always_ff @(posedge clk) begin
      if (rst) begin
        row_q        <= '0;
        summary_q[l] <= 1'b0;
      end else begin
        row_q        <= row_n;
        summary_q[l] <= |row_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_err_q <= 1'b0;
    else if (any_bad) cmd_err_q <= 1'b1;
  end

  assert_post_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (post_ok && !clr_all) |=> summary_q[$past(post_lvl[LW-1:0])]);

  assert_clear_all_R3: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (summary_q == '0));

  assert_bad_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    (post_cls == CMD_BAD && !clr_en && !clr_all) |=> ($stable(summary_q) && cmd_err_q));
endmodule

// File: rtl/irq_prio_eval.sv
module irq_prio_eval
  import irq_lvl_pkg::*;
#(
  parameter int NL    = DEF_LEVELS,
  parameter int SW_LO = DEF_SW_LO,
  parameter int SW_HI = DEF_SW_HI,
  parameter int EX_LO = DEF_EX_LO,
  parameter int EX_HI = DEF_EX_HI,
  parameter int PW    = $clog2(NL)
) (
  input  logic [NL-1:0] sw_req,
  input  logic [NL-1:0] summary,
  output logic [PW-1:0] prio,
  output logic [NL-1:0] mask
);
  always_comb begin
    prio = '0;
    mask = '0;
    // software levels first, lowest to highest
    for (int i = SW_LO; i < SW_HI; i++) begin
      if (sw_req[i]) begin
        prio    = PW'(i - SW_LO + 1);
        mask[i] = 1'b1;
      end
    end
    // external levels afterwards, so they override
    for (int i = EX_LO; i < EX_HI; i++) begin
      if (summary[i]) begin
        prio    = PW'(i);
        mask[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_commit.sv
module irq_commit
  import irq_lvl_pkg::*;
#(
  parameter int NL = DEF_LEVELS,
  parameter int PW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eval,
  input  logic [PW-1:0] prio,
  input  logic [NL-1:0] mask,
  input  logic [PW-1:0] threshold,
  input  logic          ack,
  output logic          fire_q,
  output logic          valid_q,
  output logic [NL-1:0] isr_q,
  output logic [PW-1:0] intid_q,
  output logic          ack_err_q
);
  logic [PW-1:0] lat_prio;
  logic [NL-1:0] lat_mask;
  logic          hit;

  assign hit = eval && (prio != '0) && (prio > threshold);

  always_ff @(posedge clk) begin
    if (rst) begin
      fire_q    <= 1'b0;
      valid_q   <= 1'b0;
      isr_q     <= '0;
      intid_q   <= '0;
      ack_err_q <= 1'b0;
      lat_prio  <= '0;
      lat_mask  <= '0;
    end else begin
      fire_q <= hit;
      if (ack) begin
        if (valid_q) begin
          isr_q   <= lat_mask;
          intid_q <= lat_prio;
        end else begin
          ack_err_q <= 1'b1;
        end
      end
      if (hit) begin
        lat_prio <= prio;
        lat_mask <= mask;
        valid_q  <= 1'b1;
      end else if (ack) begin
        valid_q  <= 1'b0;
      end
    end
  end

  assert_take_latch_R7: assert property (@(posedge clk) disable iff (rst)
    hit |=> (valid_q && fire_q && lat_prio > $past(threshold)));

  assert_commit_R8: assert property (@(posedge clk) disable iff (rst)
    (ack && valid_q) |=> (isr_q == $past(lat_mask) && intid_q == $past(lat_prio)));

  assert_stray_ack_R10: assert property (@(posedge clk) disable iff (rst)
    (ack && !valid_q) |=> (ack_err_q && $stable(isr_q) && $stable(intid_q)));
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LEVELS = DEF_LEVELS,
  parameter int NUM_SRC    = DEF_SOURCES,
  parameter int SW_LO      = DEF_SW_LO,
  parameter int SW_HI      = DEF_SW_HI,
  parameter int EX_LO      = DEF_EX_LO,
  parameter int EX_HI      = DEF_EX_HI,
  localparam int LIN_W     = $clog2(NUM_LEVELS) + 1,
  localparam int SIN_W     = $clog2(NUM_SRC) + 1,
  localparam int PRIO_W    = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  post_en,
  input  logic [LIN_W-1:0]      post_lvl,
  input  logic [SIN_W-1:0]      post_idx,
  input  logic                  clr_en,
  input  logic [LIN_W-1:0]      clr_lvl,
  input  logic [SIN_W-1:0]      clr_idx,
  input  logic                  clr_all,
  input  logic [NUM_LEVELS-1:0] sw_req,
  input  logic [1:0]            pc_low,
  input  logic [PRIO_W-1:0]     threshold,
  input  logic                  eval,
  input  logic                  ack,
  output logic                  irq_pending,
  output logic [NUM_LEVELS-1:0] lvl_summary,
  output logic                  fire,
  output logic                  info_valid,
  output logic [NUM_LEVELS-1:0] isr_out,
  output logic [PRIO_W-1:0]     intid_out,
  output logic                  cmd_err,
  output logic                  ack_err
);
  logic [PRIO_W-1:0]     ev_prio;
  logic [NUM_LEVELS-1:0] ev_mask;

  irq_pend_store #(.NL(NUM_LEVELS), .NS(NUM_SRC), .LIW(LIN_W), .SIW(SIN_W)) u_store (
    .clk(clk), .rst(rst),
    .post_en(post_en), .post_lvl(post_lvl), .post_idx(post_idx),
    .clr_en(clr_en), .clr_lvl(clr_lvl), .clr_idx(clr_idx),
    .clr_all(clr_all),
    .summary_q(lvl_summary), .cmd_err_q(cmd_err)
  );

  irq_prio_eval #(.NL(NUM_LEVELS), .SW_LO(SW_LO), .SW_HI(SW_HI),
                  .EX_LO(EX_LO), .EX_HI(EX_HI), .PW(PRIO_W)) u_eval (
    .sw_req(sw_req), .summary(lvl_summary), .prio(ev_prio), .mask(ev_mask)
  );

  irq_commit #(.NL(NUM_LEVELS), .PW(PRIO_W)) u_commit (
    .clk(clk), .rst(rst), .eval(eval), .prio(ev_prio), .mask(ev_mask),
    .threshold(threshold), .ack(ack),
    .fire_q(fire), .valid_q(info_valid), .isr_q(isr_out),
    .intid_q(intid_out), .ack_err_q(ack_err)
  );

  assign irq_pending = (lvl_summary != '0) && (pc_low == 2'b00);

  assert_align_gate_R4: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> (pc_low == 2'b00 && lvl_summary != '0));
endmodule

// File: tb/irq_level_ctrl_test.sv
module irq_level_ctrl_test;
  logic clk = 0;
  logic rst = 1;
  always #4 clk = ~clk;  // 125 MHz

  logic        post_en = 0, clr_en = 0, clr_all = 0, eval = 0, ack = 0;
  logic [5:0]  post_lvl = 0, clr_lvl = 0;
  logic [6:0]  post_idx = 0, clr_idx = 0;
  logic [31:0] sw_req = 0;
  logic [1:0]  pc_low = 0;
  logic [4:0]  threshold = 0;
  logic        irq_pending, fire, info_valid, cmd_err, ack_err;
  logic [31:0] lvl_summary, isr_out;
  logic [4:0]  intid_out;

  irq_level_ctrl uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference
  logic [63:0] m_pend [32];
  logic        m_fire = 0, m_valid = 0, m_cerr = 0, m_aerr = 0;
  logic [31:0] m_isr = 0, m_lmask = 0;
  int          m_id = 0, m_lprio = 0;

  function automatic logic [31:0] m_sum();
    logic [31:0] s = 0;
    for (int l = 0; l < 32; l++) s[l] = (m_pend[l] != 0);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [31:0] s = m_sum();
    int p = 0;
    logic [31:0] mk = 0;
    for (int i = 1; i < 16; i++) if (sw_req[i]) begin p = i; mk[i] = 1; end
    for (int i = 16; i < 32; i++) if (s[i]) begin p = i; mk[i] = 1; end
    if (ack) begin
      if (m_valid) begin m_isr = m_lmask; m_id = m_lprio; m_valid = 0; end
      else m_aerr = 1;
    end
    m_fire = eval && p != 0 && p > int'(threshold);
    if (m_fire) begin m_lprio = p; m_lmask = mk; m_valid = 1; end
    if ((post_en && (post_lvl >= 32 || post_idx >= 64)) ||
        (clr_en && (clr_lvl >= 32 || clr_idx >= 64))) m_cerr = 1;
    if (clr_all) begin
      for (int l = 0; l < 32; l++) m_pend[l] = 0;
    end else begin
      if (clr_en && clr_lvl < 32 && clr_idx < 64) m_pend[clr_lvl][clr_idx] = 0;
      if (post_en && post_lvl < 32 && post_idx < 64) m_pend[post_lvl][post_idx] = 1;
    end
  endtask

  task automatic compare();
    logic [31:0] s = m_sum();
    chk(lvl_summary == s, "R1/R2/R3 summary", lvl_summary, s);
    chk(irq_pending == (s != 0 && pc_low == 0), "R4 pending", irq_pending, (s != 0 && pc_low == 0));
    chk(fire == m_fire && info_valid == m_valid, "R7 fire/valid", {fire, info_valid}, {m_fire, m_valid});
    chk(isr_out == m_isr && int'(intid_out) == m_id, "R8 commit", {isr_out, 3'b0, intid_out}, {m_isr, m_id[7:0]});
    chk(cmd_err == m_cerr, "R9 cmd_err", cmd_err, m_cerr);
    chk(ack_err == m_aerr, "R10 ack_err", ack_err, m_aerr);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    post_en = 0; clr_en = 0; clr_all = 0; eval = 0; ack = 0;
  endtask

  task automatic post(input int l, input int i);
    post_en = 1; post_lvl = 6'(l); post_idx = 7'(i);
  endtask

  task automatic clr(input int l, input int i);
    clr_en = 1; clr_lvl = 6'(l); clr_idx = 7'(i);
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 32; l++) m_pend[l] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R12 reset state
    chk(lvl_summary == 0 && !fire && !info_valid && isr_out == 0 && intid_out == 0
        && !cmd_err && !ack_err && !irq_pending, "R12 reset", lvl_summary, 0);

    // R2 summary survives partial clear
    post(20, 5); step(); idle();
    post(20, 9); clr(20, 5); step(); idle();
    chk(lvl_summary[20] == 1, "R2 partial clear", lvl_summary[20], 1);
    clr(20, 9); step(); idle();
    chk(lvl_summary[20] == 0, "R2 last clear", lvl_summary[20], 0);

    // R11 post beats clear on same bit
    post(3, 1); clr(3, 1); step(); idle();
    chk(lvl_summary[3] == 1, "R11 post wins", lvl_summary[3], 1);

    // R4 misaligned address masks pending
    pc_low = 2'b01; step(); pc_low = 2'b10; step(); pc_low = 2'b00; step();

    // R9 out-of-range commands
    post(40, 2); step(); idle();
    chk(cmd_err == 1 && lvl_summary == 32'h8, "R9 bad level", lvl_summary, 32'h8);
    clr(3, 100); step(); idle();
    chk(lvl_summary[3] == 1, "R9 bad index clear", lvl_summary[3], 1);

    // R3 clear-all beats a same-cycle post
    clr_all = 1; post(25, 4); step(); idle();
    chk(lvl_summary == 0, "R3 clear-all", lvl_summary, 0);

    // R5 software levels only
    sw_req = 32'h88; threshold = 0; eval = 1; step(); idle();
    ack = 1; step(); idle();
    chk(intid_out == 7 && isr_out == 32'h88, "R5 software priority", intid_out, 7);

    // R6 external overrides software
    post(22, 0); step(); idle();
    eval = 1; step(); idle();
    ack = 1; step(); idle();
    chk(intid_out == 22 && isr_out == 32'h0040_0088, "R6 external priority", isr_out, 32'h0040_0088);

    // R7 threshold equal blocks delivery
    threshold = 22; eval = 1; step(); idle();
    chk(!fire && !info_valid, "R7 no fire at threshold", fire, 0);
    threshold = 21; eval = 1; step(); idle();
    chk(fire && info_valid, "R7 fire above threshold", fire, 1);
    // R8 ack with simultaneous new take keeps valid
    ack = 1; eval = 1; step(); idle();
    chk(info_valid == 1 && intid_out == 22, "R8 ack plus eval", info_valid, 1);
    ack = 1; step(); idle();
    // R10 stray ack
    ack = 1; step(); idle();
    chk(ack_err == 1 && intid_out == 22, "R10 stray ack", ack_err, 1);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      post_en  = ($urandom % 3) == 0;
      post_lvl = 6'($urandom % 36);
      post_idx = 7'($urandom % 68);
      clr_en   = ($urandom % 3) == 0;
      clr_lvl  = ($urandom % 2) ? post_lvl : 6'($urandom % 36);
      clr_idx  = ($urandom % 2) ? post_idx : 7'($urandom % 68);
      clr_all  = ($urandom % 40) == 0;
      sw_req   = ($urandom % 4) == 0 ? $urandom : sw_req;
      pc_low   = 2'($urandom % 4 == 0 ? $urandom : 0);
      threshold = 5'($urandom);
      eval     = ($urandom % 4) == 0;
      ack      = ($urandom % 5) == 0;
      step();
    end
    idle();
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule